// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block caches page translations for a 32-bit paged processor core. It has two first-level buffers, one for instruction fetch and one for data access. Each is fully associative and is looked up in the same cycle the request arrives. Behind them sits one shared, set-associative second-level buffer. A single miss engine serves misses from either side. It first probes the second level for one cycle. If that probe also misses, it asks an external page-walk port for the page-table entry and installs the answer.

Pages are 4 KB. Each requester drives a 32-bit linear address and holds `*_req` until it sees a hit or a fault on its side. The physical address is the cached 20-bit page frame joined to the untouched 12-bit page offset. When translation is disabled, the block passes addresses straight through and does not touch the buffers.

The miss engine has three states. `ST_IDLE` waits for a first-level miss and grants the data side first. `ST_L2` probes the second level for one cycle. On a hit it completes; on a miss it moves to `ST_WALK`. `ST_WALK` holds the walk request until a page-table entry returns, then completes. On completion the engine chains straight into `ST_L2` for a pending miss on the other side; otherwise it returns to `ST_IDLE`. A flush forces `ST_IDLE` from any state.

Top module: `xlat_two_level`

## Requirements
- R1: With `xlat_en` low, `*_hit` equals `*_req` and `*_phys` equals `*_lin` in the same cycle, and a request in `ST_IDLE` never starts a page walk.
- R2: With `xlat_en` high, a first-level hit raises `*_hit` in the cycle of the request, with `*_phys` = {cached frame, `*_lin[11:0]`}.
- R3: A first-level miss that hits the second level raises `*_hit` exactly one cycle after the request and refills that side's first level. The engine stays in `ST_L2` for one cycle per grant.
- R4: A miss in both levels raises `walk_req` two cycles after the request, with `walk_vpn` = `lin[31:12]`. `walk_req` and `walk_vpn` hold until `pte_valid`. The hit is given in the `pte_valid` cycle, and the frame `pte_ppn` is installed in the second level and in the requesting first level.
- R5: A returned entry with `pte_present` low raises `*_fault` (with `*_hit` low) in the `pte_valid` cycle and installs nothing, so a repeat of the request walks again.
- R6: Instruction and data first-level lookups happen in the same cycle and do not depend on each other. A hit on one side is not delayed by a miss on the other.
- R7: When both sides miss in the same cycle, the data side is served first. The instruction side enters `ST_L2` in the cycle right after the data side completes.
- R8: Each first-level buffer holds 8 entries. Refills overwrite them in round-robin order, so the oldest refill since reset is evicted first and no address matches two entries.
- R9: The second level holds 32 sets of 2 ways, indexed by `lin[16:12]`. A refill fills an invalid way first, otherwise the least recently used way. Both hits and refills update recency, and a frame is never installed twice in one set.
- R10: Reset and a one-cycle `flush` pulse invalidate every entry at both levels, so every later translation walks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries, abort the miss engine |
| xlat_en | input | 1 | Translation enable; low means pass-through |
| i_req | input | 1 | Instruction-side request, held until hit or fault |
| i_lin | input | 32 | Instruction-side linear address |
| i_hit | output | 1 | Instruction-side translation valid |
| i_phys | output | 32 | Instruction-side physical address |
| i_fault | output | 1 | Instruction-side page not present |
| d_req | input | 1 | Data-side request, held until hit or fault |
| d_lin | input | 32 | Data-side linear address |
| d_hit | output | 1 | Data-side translation valid |
| d_phys | output | 32 | Data-side physical address |
| d_fault | output | 1 | Data-side page not present |
| walk_req | output | 1 | Page-walk request, high in `ST_WALK` |
| walk_vpn | output | 20 | Virtual page number to walk |
| pte_valid | input | 1 | Page-table entry returned this cycle |
| pte_present | input | 1 | Returned entry maps a present page |
| pte_ppn | input | 20 | Returned physical frame number |

## Verification
The bench focuses on the exact cycle in which each side completes, because the errors that matter here are timing errors. A design with an extra register in the second-level path would answer one cycle late. A design that serves the instruction side first, or that returns to idle instead of chaining, would let the instruction side finish early or late after a simultaneous miss. When both sides miss on the same page, the instruction side must hit in the second level right after the data walk; a broken refill would make it walk a second time. The bench also fills nine pages on one side to catch a first-level pointer that evicts the wrong entry. It puts three pages in one second-level set to catch recency that ignores hits. It repeats a non-present page to catch an entry that was installed despite the fault.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned VPN_W  = ADDR_W - OFF_W;
    localparam int unsigned PPN_W  = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L2,
        ST_WALK
    } eng_state_e;

    typedef enum logic {
        SIDE_I,
        SIDE_D
    } side_e;
endpackage

// File: rtl/tlb_l1.sv
module tlb_l1
    import xlt_pkg::*;
#(
    parameter int unsigned ENTRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  vpn_t lk_vpn,
    output logic lk_hit,
    output ppn_t lk_ppn,
    input  logic wr_en,
    input  vpn_t wr_vpn,
    input  ppn_t wr_ppn
);
    localparam int unsigned PTR_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] vld;
    vpn_t               tag [ENTRIES];
    ppn_t               frame [ENTRIES];
    logic [PTR_W-1:0]   ptr;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == lk_vpn);
    end

    always_comb begin
        lk_ppn = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (match[k]) lk_ppn = lk_ppn | frame[k];
        end
        lk_hit = |match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag[ptr]   <= wr_vpn;
            frame[ptr] <= wr_ppn;
        end
    end

    // R8: a refill never duplicates an address, so at most one entry matches
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_l2.sv
module tlb_l2
    import xlt_pkg::*;
#(
    parameter int unsigned SETS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  vpn_t rd_vpn,
    input  logic touch,
    output logic rd_hit,
    output ppn_t rd_ppn,
    input  logic wr_en,
    input  vpn_t wr_vpn,
    input  ppn_t wr_ppn
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = VPN_W - IDX_W;

    logic [1:0]       vld   [SETS];
    logic [TAG_W-1:0] tag   [SETS][2];
    ppn_t             frame [SETS][2];
    logic             lru   [SETS];

    logic [IDX_W-1:0] ridx, widx;
    logic [TAG_W-1:0] rtag, wtag;
    logic [1:0]       hit_w, wmatch;
    logic             victim;
    logic             wr_present;

    assign ridx = rd_vpn[IDX_W-1:0];
    assign rtag = rd_vpn[VPN_W-1:IDX_W];
    assign widx = wr_vpn[IDX_W-1:0];
    assign wtag = wr_vpn[VPN_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            hit_w[w]  = vld[ridx][w] && (tag[ridx][w] == rtag);
            wmatch[w] = vld[widx][w] && (tag[widx][w] == wtag);
        end
        rd_hit     = |hit_w;
        rd_ppn     = hit_w[1] ? frame[ridx][1] : frame[ridx][0];
        wr_present = |wmatch;
        if (!vld[widx][0])      victim = 1'b0;
        else if (!vld[widx][1]) victim = 1'b1;
        else                    victim = lru[widx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                lru[s] <= 1'b0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (wr_en) begin
            vld[widx][victim] <= 1'b1;
            lru[widx]         <= ~victim;
        end else if (touch && rd_hit) begin
            lru[ridx] <= ~hit_w[1];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag[widx][victim]   <= wtag;
            frame[widx][victim] <= wr_ppn;
        end
    end

    // R9: a walk is only started on a miss, so the frame is never already in the set
    p_no_dup_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_present);
endmodule

// File: rtl/xlat_two_level.sv
module xlat_two_level
    import xlt_pkg::*;
#(
    parameter int unsigned L1_ENTRIES = 8,
    parameter int unsigned L2_SETS    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        xlat_en,
    input  logic        i_req,
    input  logic [31:0] i_lin,
    output logic        i_hit,
    output logic [31:0] i_phys,
    output logic        i_fault,
    input  logic        d_req,
    input  logic [31:0] d_lin,
    output logic        d_hit,
    output logic [31:0] d_phys,
    output logic        d_fault,
    output logic        walk_req,
    output logic [19:0] walk_vpn,
    input  logic        pte_valid,
    input  logic        pte_present,
    input  logic [19:0] pte_ppn
);
    eng_state_e state, nstate;
    side_e      side, nside;
    vpn_t       vpn_q, nvpn;

    vpn_t i_vpn, d_vpn;
    logic i_l1_hit, d_l1_hit, l2_hit;
    ppn_t i_l1_ppn, d_l1_ppn, l2_ppn, fill_ppn;
    logic need_i, need_d;
    logic l2_done, walk_done, done, done_ok, walk_ok;
    logic fill_i, fill_d, serve_i, serve_d;

    assign i_vpn = i_lin[31:OFF_W];
    assign d_vpn = d_lin[31:OFF_W];

    tlb_l1 #(.ENTRIES(L1_ENTRIES)) u_l1_i (
        .clk, .rst_n, .flush,
        .lk_vpn(i_vpn), .lk_hit(i_l1_hit), .lk_ppn(i_l1_ppn),
        .wr_en(fill_i), .wr_vpn(vpn_q), .wr_ppn(fill_ppn)
    );

    tlb_l1 #(.ENTRIES(L1_ENTRIES)) u_l1_d (
        .clk, .rst_n, .flush,
        .lk_vpn(d_vpn), .lk_hit(d_l1_hit), .lk_ppn(d_l1_ppn),
        .wr_en(fill_d), .wr_vpn(vpn_q), .wr_ppn(fill_ppn)
    );

    tlb_l2 #(.SETS(L2_SETS)) u_l2 (
        .clk, .rst_n, .flush,
        .rd_vpn(vpn_q), .touch(state == ST_L2 && !flush),
        .rd_hit(l2_hit), .rd_ppn(l2_ppn),
        .wr_en(walk_ok), .wr_vpn(vpn_q), .wr_ppn(pte_ppn)
    );

    assign need_i    = xlat_en && i_req && !i_l1_hit;
    assign need_d    = xlat_en && d_req && !d_l1_hit;
    assign l2_done   = (state == ST_L2) && l2_hit;
    assign walk_done = (state == ST_WALK) && pte_valid;
    assign done      = l2_done || walk_done;
    assign done_ok   = l2_done || (walk_done && pte_present);
    assign walk_ok   = walk_done && pte_present && !flush;
    assign fill_ppn  = (state == ST_L2) ? l2_ppn : pte_ppn;
    assign serve_i   = done && (side == SIDE_I);
    assign serve_d   = done && (side == SIDE_D);
    assign fill_i    = serve_i && done_ok && !flush;
    assign fill_d    = serve_d && done_ok && !flush;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            side  <= SIDE_I;
            vpn_q <= '0;
        end else begin
            state <= nstate;
            side  <= nside;
            vpn_q <= nvpn;
        end
    end

    // transitions: grant, probe, walk, chain to the other side
    always_comb begin
        nstate = state;
        nside  = side;
        nvpn   = vpn_q;
        unique case (state)
            ST_IDLE: begin
                if (need_d) begin
                    nstate = ST_L2; nside = SIDE_D; nvpn = d_vpn;
                end else if (need_i) begin
                    nstate = ST_L2; nside = SIDE_I; nvpn = i_vpn;
                end
            end
            ST_L2:   if (!l2_hit) nstate = ST_WALK;
            ST_WALK: ;
            default: nstate = ST_IDLE;
        endcase
        if (done) begin
            if (side == SIDE_D && need_i) begin
                nstate = ST_L2; nside = SIDE_I; nvpn = i_vpn;
            end else if (side == SIDE_I && need_d) begin
                nstate = ST_L2; nside = SIDE_D; nvpn = d_vpn;
            end else begin
                nstate = ST_IDLE;
            end
        end
        if (flush) nstate = ST_IDLE;
    end

    // outputs
    always_comb begin
        walk_req = (state == ST_WALK);
        walk_vpn = vpn_q;
        if (!xlat_en) begin
            i_hit = i_req;  i_phys = i_lin;  i_fault = 1'b0;
            d_hit = d_req;  d_phys = d_lin;  d_fault = 1'b0;
        end else begin
            i_hit   = i_req && (i_l1_hit || (serve_i && done_ok));
            i_phys  = {(i_l1_hit ? i_l1_ppn : fill_ppn), i_lin[OFF_W-1:0]};
            i_fault = serve_i && walk_done && !pte_present;
            d_hit   = d_req && (d_l1_hit || (serve_d && done_ok));
            d_phys  = {(d_l1_ppn & {PPN_W{d_l1_hit}}) | (fill_ppn & {PPN_W{!d_l1_hit}}),
                       d_lin[OFF_W-1:0]};
            d_fault = serve_d && walk_done && !pte_present;
        end
    end

    p_idle_nowalk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !xlat_en) |=> !walk_req);

    p_l2_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L2 && !flush) |=> (state != ST_L2 || side != $past(side)));

    p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !pte_valid && !flush) |=> (walk_req && $stable(walk_vpn)));

    p_fault_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_fault && i_hit) && !(d_fault && d_hit));

    p_data_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && need_d && need_i && !flush) |=> (state == ST_L2 && side == SIDE_D));
endmodule

// File: tb/xlat_two_level_test.sv
module xlat_two_level_test;
    logic        clk = 1'b0;
    logic        rst_n, flush, xlat_en;
    logic        i_req, d_req;
    logic [31:0] i_lin, d_lin;
    logic        i_hit, d_hit, i_fault, d_fault;
    logic [31:0] i_phys, d_phys;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        pte_valid, pte_present;
    logic [19:0] pte_ppn;

    int n_chk = 0;
    int n_bad = 0;
    int wcnt  = 0;

    localparam logic [19:0] XMASK = 20'h5A5A5;

    always #2 clk = ~clk;

    xlat_two_level uut (
        .clk, .rst_n, .flush, .xlat_en,
        .i_req, .i_lin, .i_hit, .i_phys, .i_fault,
        .d_req, .d_lin, .d_hit, .d_phys, .d_fault,
        .walk_req, .walk_vpn, .pte_valid, .pte_present, .pte_ppn
    );

    // page-walk responder: entry returned in the third cycle of walk_req
    always @(negedge clk) begin
        if (walk_req && !pte_valid) begin
            if (wcnt == 2) begin
                pte_valid   = 1'b1;
                pte_ppn     = walk_vpn ^ XMASK;
                pte_present = (walk_vpn[19:16] != 4'hF);
                wcnt        = 0;
            end else begin
                wcnt = wcnt + 1;
            end
        end else begin
            pte_valid = 1'b0;
        end
    end

    // behavioural reference: recency-ordered queues
    logic [19:0] qi[$];
    logic [19:0] qd[$];
    logic [19:0] q2[$];

    function automatic bit l1_has(int sd, logic [19:0] v);
        if (sd == 1) begin
            foreach (qd[k]) if (qd[k] == v) return 1'b1;
        end else begin
            foreach (qi[k]) if (qi[k] == v) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int l2_pos(logic [19:0] v);
        foreach (q2[k]) if (q2[k] == v) return k;
        return -1;
    endfunction

    function automatic int classify(int sd, logic [19:0] v);
        if (l1_has(sd, v)) return 0;
        if (l2_pos(v) >= 0) return 1;
        return 2;
    endfunction

    function automatic int lat_of(int c);
        return (c == 0) ? 0 : (c == 1) ? 1 : 4;
    endfunction

    function automatic bit present(logic [19:0] v);
        return v[19:16] != 4'hF;
    endfunction

    task automatic l1_add(int sd, logic [19:0] v);
        if (sd == 1) begin
            qd.push_back(v);
            if (qd.size() > 8) void'(qd.pop_front());
        end else begin
            qi.push_back(v);
            if (qi.size() > 8) void'(qi.pop_front());
        end
    endtask

    task automatic l2_add(logic [19:0] v);
        int cnt = 0;
        int first = -1;
        foreach (q2[k]) if (q2[k][4:0] == v[4:0]) begin
            cnt++;
            if (first < 0) first = k;
        end
        if (cnt >= 2) q2.delete(first);
        q2.push_back(v);
    endtask

    task automatic model_update(int sd, logic [19:0] v, int c);
        int p;
        if (c == 1) begin
            p = l2_pos(v);
            q2.delete(p);
            q2.push_back(v);
            l1_add(sd, v);
        end else if (c == 2 && present(v)) begin
            l2_add(v);
            l1_add(sd, v);
        end
    endtask

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_side(int sd, int c, int lat, bit flt, logic [19:0] v,
                              logic [31:0] lin, string tag);
        logic h, f;
        logic [31:0] ph;
        h  = (sd == 1) ? d_hit : i_hit;
        f  = (sd == 1) ? d_fault : i_fault;
        ph = (sd == 1) ? d_phys : i_phys;
        if (c < lat)
            chk(!h && !f, tag, "early hit/fault", {30'd0, h, f}, 32'd0);
        else if (flt)
            chk(f && !h, tag, "fault flag", {30'd0, h, f}, 32'd1);
        else
            chk(h && !f && ph == {v ^ XMASK, lin[11:0]}, tag, "phys",
                h ? ph : 32'hDEAD_0000, {v ^ XMASK, lin[11:0]});
    endtask

    task automatic single(int sd, logic [31:0] lin, string tag);
        logic [19:0] v;
        int c0, lat;
        bit flt;
        v   = lin[31:12];
        c0  = classify(sd, v);
        lat = lat_of(c0);
        flt = (c0 == 2) && !present(v);
        @(negedge clk);
        if (sd == 1) begin d_req = 1'b1; d_lin = lin; end
        else         begin i_req = 1'b1; i_lin = lin; end
        for (int c = 0; c <= lat; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            check_side(sd, c, lat, flt, v, lin, tag);
            if (lat == 4 && c == 2)
                chk(walk_req && walk_vpn == v, "R4", "walk request", {11'd0, walk_req, walk_vpn},
                    {12'd1, v});
        end
        @(negedge clk);
        d_req = 1'b0;
        i_req = 1'b0;
        model_update(sd, v, c0);
    endtask

    task automatic dual(logic [31:0] dl, logic [31:0] il, string tag);
        logic [19:0] vd, vi;
        int cd, ld, ci, li, last;
        bit fd, fi;
        vd = dl[31:12];
        vi = il[31:12];
        cd = classify(1, vd);
        ld = lat_of(cd);
        fd = (cd == 2) && !present(vd);
        ci = l1_has(0, vi) ? 0 : -1;
        model_update(1, vd, cd);
        if (ci == 0) li = 0;
        else begin
            ci = classify(0, vi);
            li = ((cd == 0) ? 1 : ld + 1) + ((ci == 1) ? 0 : 3);
        end
        fi = (ci == 2) && !present(vi);
        last = (ld > li) ? ld : li;
        @(negedge clk);
        d_req = 1'b1; d_lin = dl;
        i_req = 1'b1; i_lin = il;
        for (int c = 0; c <= last; c++) begin
            if (c > 0) begin
                @(negedge clk);
                if (c == ld + 1) d_req = 1'b0;
                if (c == li + 1) i_req = 1'b0;
            end
            #1;
            if (c <= ld) check_side(1, c, ld, fd, vd, dl, tag);
            if (c <= li) check_side(0, c, li, fi, vi, il, tag);
        end
        @(negedge clk);
        d_req = 1'b0;
        i_req = 1'b0;
        model_update(0, vi, ci);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        qi.delete();
        qd.delete();
        q2.delete();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; xlat_en = 1'b0;
        i_req = 1'b0; d_req = 1'b0; i_lin = '0; d_lin = '0;
        pte_valid = 1'b0; pte_present = 1'b0; pte_ppn = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        xlat_en = 1'b1;
        #1;
        // R10: reset leaves nothing valid and no walk
        chk(!i_hit && !d_hit && !walk_req, "R10", "reset outputs",
            {29'd0, i_hit, d_hit, walk_req}, 32'd0);

        // R1: pass-through, same cycle, no walk, nothing installed
        @(negedge clk);
        xlat_en = 1'b0;
        i_req = 1'b1; i_lin = 32'hABCD_E123;
        d_req = 1'b1; d_lin = 32'h1357_9BDF;
        #1;
        chk(i_hit && i_phys == 32'hABCD_E123, "R1", "i bypass", i_phys, 32'hABCD_E123);
        chk(d_hit && d_phys == 32'h1357_9BDF, "R1", "d bypass", d_phys, 32'h1357_9BDF);
        @(negedge clk);
        #1;
        chk(!walk_req, "R1", "no walk", {31'd0, walk_req}, 32'd0);
        @(negedge clk);
        i_req = 1'b0; d_req = 1'b0;
        xlat_en = 1'b1;
        single(1, 32'h1357_9BDF, "R1");   // page not installed by the bypass: walks

        // R4 then R2, R3
        single(1, 32'h1234_5678, "R4");
        single(1, 32'h1234_5ABC, "R2");
        single(0, 32'h1234_5001, "R3");
        single(0, 32'h1234_5FFF, "R2");

        // R5: not present, not installed
        single(1, 32'hF000_1010, "R5");
        single(1, 32'hF000_1020, "R5");

        // R6: both sides hit together
        dual(32'h1234_5004, 32'h1234_5008, "R6");
        // R7: same new page on both sides
        dual(32'h2222_2100, 32'h2222_2200, "R7");
        // R6: data side hits while instruction side walks
        dual(32'h1234_5300, 32'h3333_3400, "R6");
        // R7: two different new pages
        dual(32'h4444_4010, 32'h5555_5020, "R7");

        // R8: fill nine pages on the data side, then revisit the evicted ones
        for (int k = 0; k < 9; k++) single(1, {20'h40000 + 20'(k), 12'h0A0}, "R8");
        single(1, 32'h4000_0BB0, "R8");
        single(1, 32'h4000_8BB0, "R8");
        single(1, 32'h4000_2BB0, "R8");

        // R9: three pages in set 5
        single(1, 32'h5000_5000, "R9");
        single(1, 32'h6000_5000, "R9");
        single(0, 32'h5000_5004, "R9");
        single(1, 32'h7000_5000, "R9");
        single(0, 32'h6000_5008, "R9");
        single(0, 32'h7000_500C, "R9");

        // R10: flush clears everything
        do_flush();
        single(1, 32'h1234_5678, "R10");
        single(0, 32'h2222_2000, "R10");
        dual(32'h2222_2040, 32'h1234_5040, "R10");

        summary();
    end
endmodule